// File: doc/BRIEF.md
# Configuration Frame Readback Sequencer

This block reads a run of configuration frames back out of a device through a 32-bit internal configuration port. A one-cycle start pulse supplies a starting frame address and a number of frames. The sequencer then writes a fixed command stream to the port, one word per cycle. The stream opens with a dummy and sync pair. It goes on to reset the checksum, issue the read-configuration command, load the frame address, and request the data with a packet header whose count covers the wanted frames plus one extra frame. The port is modelled as a plain word interface: a write strobe with data, and a read enable answered by a read-valid flag with data.

Once the commands have been written, the port is switched to read mode and returned words are taken one at a time. The configuration pipeline returns one throwaway frame of 81 words ahead of the real data. The sequencer drops that frame and passes every later word, in order, onto a valid/ready output stream. When the output is held, the port is not read. Status outputs report busy, normal completion and a read-phase timeout.

Top module: `cfg_readback_seq`

## Requirements
- R1: A start pulse while idle raises busy in the next cycle and starts a write burst of one word per cycle, beginning with 0xFFFFFFFF and then 0xAA995566.
- R2: Next come two no-ops (0x20000000), the command header 0x30008001 with value 7, two no-ops, 0x30008001 with value 4, then three no-ops.
- R3: The address load follows as 0x30002001 and then the frame address latched at start.
- R4: With N frames requested, the word count is 81*(N+1). When that count is 2047 or less, the data request is the single word 0x28006000 OR count, followed by two no-ops, and the burst ends.
- R5: When the count exceeds 2047, the request is 0x28006000 (zero count) followed by 0x48000000 OR count, then two no-ops.
- R6: A frame count of 0 is treated as 1, giving a count of 162 and 81 forwarded words.
- R7: Read enable stays low during the write burst and rises after its last word. A word is taken only in a cycle with read enable and read-valid both high. The first 81 words taken are discarded, and the remaining 81*N are forwarded in the order taken.
- R8: While outValid is high and outReady is low, outValid and outData hold steady and read enable is low.
- R9: After the last forwarded word is accepted, busy falls and done is high. Done stays high until the next start.
- R10: If the read phase lasts timeoutLimit+1 cycles without the last word being taken, error goes high, busy falls, read enable drops and no word is forwarded. Error stays high until the next start.
- R11: A start pulse while busy has no effect on the write burst or on the forwarded data.
- R12: During and after reset, busy, done, error, portWrEn, portRdEn and outValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Start a readback (sampled when idle) |
| frameAddr | input | 32 | Starting frame address |
| frameCount | input | FCW | Number of real frames wanted (0 acts as 1) |
| timeoutLimit | input | TW | Read-phase cycle budget |
| portWrEn | output | 1 | Port write strobe |
| portWrData | output | 32 | Port write word |
| portRdEn | output | 1 | Port read enable |
| portRdValid | input | 1 | Port returned-word valid |
| portRdData | input | 32 | Port returned word |
| outValid | output | 1 | Output stream valid |
| outReady | input | 1 | Output stream ready |
| outData | output | 32 | Output stream word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last readback completed |
| error | output | 1 | Last readback timed out |

## Verification
The bench targets the exact write burst, both header forms, and the 24/25-frame edge where the count no longer fits the short field. A count off by one frame, or a header left unsplit, shows up as a wrong burst word. Gaps in read-valid combined with random output back-pressure check that exactly the first 81 words are dropped. A design that miscounts the throwaway frame, or that reads while its output is held, drops, repeats or shifts words in the scoreboard. A silent port checks that the timeout fires in the exact cycle, and a start pulse during a burst checks that a second request cannot corrupt the first.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int FRAME_WORDS = 81;
  localparam int SHORT_MAX   = 2047;

  localparam logic [31:0] W_DUMMY   = 32'hFFFF_FFFF;
  localparam logic [31:0] W_SYNC    = 32'hAA99_5566;
  localparam logic [31:0] W_NOOP    = 32'h2000_0000;
  localparam logic [31:0] W_CMD_HDR = 32'h3000_8001;
  localparam logic [31:0] W_RST_CRC = 32'h0000_0007;
  localparam logic [31:0] W_RD_CFG  = 32'h0000_0004;
  localparam logic [31:0] W_ADR_HDR = 32'h3000_2001;
  localparam logic [31:0] W_RD_T1   = 32'h2800_6000;
  localparam logic [31:0] W_RD_T2   = 32'h4800_0000;

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_READ, ST_DRAIN} seqState_t;

  typedef struct packed {
    logic load;
    logic wrStep;
    logic rdMode;
    logic abort;
  } seqStrobe_t;

  typedef struct packed {
    logic wrLast;
    logic rxLast;
    logic tmoHit;
    logic outFull;
  } seqFlag_t;
endpackage

// File: rtl/rbs_dpath.sv
module rbs_dpath
  import rbs_pkg::*;
#(
  parameter int FCW = 12,
  parameter int TW  = 20
) (
  input  logic           clk,
  input  logic           rstN,
  input  seqStrobe_t     stb,
  input  logic [31:0]    frameAddr,
  input  logic [FCW-1:0] frameCount,
  input  logic [TW-1:0]  timeoutLimit,
  output logic [31:0]    portWrData,
  output logic           portRdEn,
  input  logic           portRdValid,
  input  logic [31:0]    portRdData,
  output logic           outValid,
  output logic [31:0]    outData,
  input  logic           outReady,
  output seqFlag_t       flg
);
  localparam int CW = $clog2(FRAME_WORDS * ((1 << FCW) + 1) + 1);

  logic [31:0]    addrQ;
  logic [CW-1:0]  wordCnt;
  logic [CW-1:0]  rxCnt;
  logic           longCnt;
  logic [4:0]     wrIdx;
  logic [TW-1:0]  tmoCnt;
  logic [FCW-1:0] nFrames;
  logic [CW-1:0]  wordCntNext;
  logic           canTake;
  logic           rdTake;

  function automatic logic [31:0] preWord(input logic [3:0] idx);
    case (idx)
      4'd0:    return W_DUMMY;
      4'd1:    return W_SYNC;
      4'd4:    return W_CMD_HDR;
      4'd5:    return W_RST_CRC;
      4'd8:    return W_CMD_HDR;
      4'd9:    return W_RD_CFG;
      4'd13:   return W_ADR_HDR;
      default: return W_NOOP;
    endcase
  endfunction

  always_comb begin
    nFrames     = (frameCount == '0) ? FCW'(1) : frameCount;
    wordCntNext = CW'(FRAME_WORDS) * (CW'(nFrames) + CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wordCnt <= '0;
      longCnt <= 1'b0;
      wrIdx   <= '0;
    end else if (stb.load) begin
      addrQ   <= frameAddr;
      wordCnt <= wordCntNext;
      longCnt <= wordCntNext > CW'(SHORT_MAX);
      wrIdx   <= '0;
    end else if (stb.wrStep) begin
      wrIdx <= wrIdx + 5'd1;
    end
  end

  always_comb begin
    if (wrIdx < 5'd14)                portWrData = preWord(wrIdx[3:0]);
    else if (wrIdx == 5'd14)          portWrData = addrQ;
    else if (wrIdx == 5'd15)          portWrData = longCnt ? W_RD_T1 : (W_RD_T1 | 32'(wordCnt));
    else if (wrIdx == 5'd16 && longCnt) portWrData = W_RD_T2 | 32'(wordCnt);
    else                              portWrData = W_NOOP;
  end

  assign canTake  = !outValid || outReady;
  assign portRdEn = stb.rdMode && canTake;
  assign rdTake   = portRdEn && portRdValid;

  always_ff @(posedge clk) begin
    if (!rstN || stb.load) rxCnt <= '0;
    else if (rdTake)       rxCnt <= rxCnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (stb.abort || stb.load) begin
      outValid <= 1'b0;
    end else if (rdTake && rxCnt >= CW'(FRAME_WORDS)) begin
      outValid <= 1'b1;
      outData  <= portRdData;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !stb.rdMode) tmoCnt <= '0;
    else                      tmoCnt <= tmoCnt + TW'(1);
  end

  assign flg.wrLast  = wrIdx == (longCnt ? 5'd18 : 5'd17);
  assign flg.rxLast  = canTake && portRdValid && (rxCnt == wordCnt - CW'(1));
  assign flg.tmoHit  = tmoCnt == timeoutLimit;
  assign flg.outFull = outValid;
endmodule

// File: rtl/rbs_ctrl.sv
module rbs_ctrl
  import rbs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  seqFlag_t   flg,
  output seqStrobe_t stb,
  output logic       portWrEn,
  output logic       busy,
  output logic       done,
  output logic       error
);
  seqState_t state, nxt;

  always_comb begin
    stb = '0;
    nxt = state;
    case (state)
      ST_IDLE: if (startPulse) begin
        stb.load = 1'b1;
        nxt      = ST_WRITE;
      end
      ST_WRITE: begin
        stb.wrStep = 1'b1;
        if (flg.wrLast) nxt = ST_READ;
      end
      ST_READ: begin
        stb.rdMode = 1'b1;
        if (flg.tmoHit) begin
          stb.abort = 1'b1;
          nxt       = ST_IDLE;
        end else if (flg.rxLast) begin
          nxt = ST_DRAIN;
        end
      end
      ST_DRAIN: if (!flg.outFull) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= nxt;
      if (stb.load) begin
        done  <= 1'b0;
        error <= 1'b0;
      end else if (stb.abort) begin
        error <= 1'b1;
      end else if (state == ST_DRAIN && nxt == ST_IDLE) begin
        done <= 1'b1;
      end
    end
  end

  assign portWrEn = state == ST_WRITE;
  assign busy     = state != ST_IDLE;
endmodule

// File: rtl/cfg_readback_seq.sv
module cfg_readback_seq
  import rbs_pkg::*;
#(
  parameter int FCW = 12,
  parameter int TW  = 20
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           startPulse,
  input  logic [31:0]    frameAddr,
  input  logic [FCW-1:0] frameCount,
  input  logic [TW-1:0]  timeoutLimit,
  output logic           portWrEn,
  output logic [31:0]    portWrData,
  output logic           portRdEn,
  input  logic           portRdValid,
  input  logic [31:0]    portRdData,
  output logic           outValid,
  input  logic           outReady,
  output logic [31:0]    outData,
  output logic           busy,
  output logic           done,
  output logic           error
);
  seqStrobe_t stb;
  seqFlag_t   flg;

  rbs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .flg(flg), .stb(stb),
    .portWrEn(portWrEn), .busy(busy), .done(done), .error(error)
  );

  rbs_dpath #(.FCW(FCW), .TW(TW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .frameAddr(frameAddr),
    .frameCount(frameCount), .timeoutLimit(timeoutLimit),
    .portWrData(portWrData), .portRdEn(portRdEn), .portRdValid(portRdValid),
    .portRdData(portRdData), .outValid(outValid), .outData(outData),
    .outReady(outReady), .flg(flg)
  );
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker (
  input logic        clk,
  input logic        rstN,
  input logic        startPulse,
  input logic        portWrEn,
  input logic [31:0] portWrData,
  input logic        portRdEn,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outData,
  input logic        busy,
  input logic        done,
  input logic        error
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startPulse) |=> busy); // R1
  AST_BURST_DUMMY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(portWrEn) |-> portWrData == 32'hFFFF_FFFF); // R1
  AST_BURST_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(portWrEn) |=> portWrData == 32'hAA99_5566); // R1
  AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(portWrEn && portRdEn)); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R8
  AST_NO_TAKE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !portRdEn); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (!busy && !outValid && !portRdEn)); // R10
endmodule

bind cfg_readback_seq rbs_checker u_rbs_checker (.*);

// File: tb/test_cfg_readback_seq.sv
`timescale 1ns/1ps
module test_cfg_readback_seq;
  localparam int FCW = 12;
  localparam int TW  = 20;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           startPulse = 1'b0;
  logic [31:0]    frameAddr = '0;
  logic [FCW-1:0] frameCount = '0;
  logic [TW-1:0]  timeoutLimit = '1;
  logic           portWrEn, portRdEn, outValid, busy, done, error;
  logic [31:0]    portWrData, outData;
  logic           portRdValid = 1'b0;
  logic [31:0]    portRdData = '0;
  logic           outReady = 1'b1;

  int checks = 0, failures = 0;
  logic [31:0] expQ[$];
  logic [31:0] expWr[$];
  logic [31:0] actWr[$];
  int  rdIdx = 0, rdEnCycles = 0;
  logic [7:0] runTag = 8'h00;
  bit  silent = 0, gaps = 0, backPress = 0, active = 0;

  cfg_readback_seq #(.FCW(FCW), .TW(TW)) i_cfg_readback_seq (.*);

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // port model, stream sink and scoreboard monitor
  initial begin
    bit offered = 0;
    bit held = 0;
    logic [31:0] heldData = '0;
    forever begin
      @(negedge clk);
      if (portWrEn) actWr.push_back(portWrData);
      if (offered) rdIdx++;
      if (held) check(outValid && outData == heldData, "R8", "stalled word changed", outData, heldData);
      outReady = backPress ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      if (portRdEn) rdEnCycles++;
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(0, "R7", "unexpected output word", outData, 32'h0);
        else begin
          logic [31:0] e;
          e = expQ.pop_front();
          check(outData == e, "R7", "output word", outData, e);
        end
      end
      held = outValid && !outReady;
      if (held) check(!portRdEn, "R8", "read enable while output held", 32'(portRdEn), 32'h0);
      heldData = outData;
      portRdValid = portRdEn && !silent && (!gaps || $urandom_range(0, 3) != 0);
      portRdData  = {runTag, 24'(rdIdx)};
      offered = portRdValid;
    end
  end

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog global timeout actual=%h expected=%h", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic buildWrites(input logic [31:0] addr, input int frames);
    int n, cnt;
    n = (frames == 0) ? 1 : frames;
    cnt = 81 * (n + 1);
    expWr = {32'hFFFF_FFFF, 32'hAA99_5566, 32'h2000_0000, 32'h2000_0000,
             32'h3000_8001, 32'h0000_0007, 32'h2000_0000, 32'h2000_0000,
             32'h3000_8001, 32'h0000_0004, 32'h2000_0000, 32'h2000_0000,
             32'h2000_0000, 32'h3000_2001, addr};
    if (cnt <= 2047) expWr.push_back(32'h2800_6000 | 32'(cnt));
    else begin
      expWr.push_back(32'h2800_6000);
      expWr.push_back(32'h4800_0000 | 32'(cnt));
    end
    expWr.push_back(32'h2000_0000);
    expWr.push_back(32'h2000_0000);
  endtask

  task automatic doRun(input logic [31:0] addr, input int frames, input logic [7:0] tag,
                       input bit intrude, input string req);
    int n, waited;
    n = (frames == 0) ? 1 : frames;
    runTag = tag;
    rdIdx = 0;
    actWr.delete();
    buildWrites(addr, frames);
    if (!silent) for (int k = 81; k < 81 * (n + 1); k++) expQ.push_back({tag, 24'(k)});
    @(negedge clk);
    frameAddr = addr;
    frameCount = FCW'(frames);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    rdEnCycles = 0;
    check(busy, "R1", "busy after start", 32'(busy), 32'h1);
    if (intrude) begin
      repeat (4) @(negedge clk);
      frameAddr = 32'hDEAD_0000;
      frameCount = FCW'(7);
      startPulse = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
    end
    waited = 0;
    while (!(done || error) && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    if (waited >= 20000) check(0, req, "run watchdog", 32'h0, 32'h1);
    check(actWr.size() == expWr.size(), req, "write burst length", 32'(actWr.size()), 32'(expWr.size()));
    for (int i = 0; i < expWr.size() && i < actWr.size(); i++)
      if (actWr[i] != expWr[i]) begin
        check(0, req, $sformatf("write word %0d", i), actWr[i], expWr[i]);
        break;
      end
    check(!busy, req, "busy after finish", 32'(busy), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !portWrEn && !portRdEn && !outValid, "R12",
          "outputs in reset", {26'h0, busy, done, error, portWrEn, portRdEn, outValid}, 32'h0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !error && !portWrEn && !portRdEn && !outValid, "R12",
          "outputs after reset", {26'h0, busy, done, error, portWrEn, portRdEn, outValid}, 32'h0);

    // R1 R2 R3 R4 R7 R9: single frame, free-flowing
    doRun(32'h0030_8000, 1, 8'h11, 0, "R4");
    check(done && !error, "R9", "done after single frame", {30'h0, done, error}, 32'h2);
    check(expQ.size() == 0, "R7", "words left undelivered", 32'(expQ.size()), 32'h0);

    // R7 R8 R11: gaps, back-pressure and a start pulse mid-burst
    gaps = 1; backPress = 1;
    doRun(32'h0000_0100, 3, 8'h22, 1, "R11");
    check(done, "R9", "done after three frames", 32'(done), 32'h1);
    check(expQ.size() == 0, "R11", "intruding start changed output", 32'(expQ.size()), 32'h0);

    // R6: zero frames acts as one
    gaps = 0; backPress = 0;
    doRun(32'h0000_0200, 0, 8'h33, 0, "R6");
    check(expQ.size() == 0 && done, "R6", "zero frame run output", 32'(expQ.size()), 32'h0);

    // R4 boundary: 24 frames still uses the short header
    backPress = 1;
    doRun(32'h0010_0000, 24, 8'h44, 0, "R4");
    check(expQ.size() == 0 && done, "R4", "24 frame run output", 32'(expQ.size()), 32'h0);

    // R5: 25 frames needs the long header pair
    backPress = 0; gaps = 1;
    doRun(32'h0020_0080, 25, 8'h55, 0, "R5");
    check(expQ.size() == 0 && done, "R5", "25 frame run output", 32'(expQ.size()), 32'h0);

    // R10: silent port times out
    gaps = 0; silent = 1; timeoutLimit = TW'(40);
    doRun(32'h0000_0300, 2, 8'h66, 0, "R10");
    check(error && !done, "R10", "error after silent port", {30'h0, error, done}, 32'h2);
    check(rdEnCycles == 41, "R10", "read-phase cycles before timeout", 32'(rdEnCycles), 32'd41);
    repeat (3) @(negedge clk);
    check(!portRdEn && !outValid && !busy && error, "R10", "quiet after timeout",
          {28'h0, portRdEn, outValid, busy, error}, 32'h1);

    // R9 R10: a new run clears error and completes
    silent = 0; timeoutLimit = '1;
    doRun(32'h0000_0400, 2, 8'h77, 0, "R9");
    check(done && !error, "R9", "done after recovery", {30'h0, done, error}, 32'h2);
    check(expQ.size() == 0, "R9", "recovery output", 32'(expQ.size()), 32'h0);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule